// File: doc/BRIEF.md
# Vectored Interrupt Entry Sequencer

This block takes a small 8-bit controller core into a reset or interrupt handler. It looks at a reset request, a vector of pending hardware sources, the global interrupt-enable flag and a skip-pending flag. When entry is allowed, it picks one winner. It then writes the current program-counter word address onto the stack, one byte per memory handshake, and finishes with a single load cycle. In that cycle it hands the core the new program counter, the new stack pointer, a request to clear the global enable flag and a mask for the serviced pending bit.

The stack writes leave through a byte-wide valid/ready stream. `wr_valid_o` rises in the cycle after acceptance and stays high until the last byte is taken. While `wr_ready_i` is low, address and data hold still. A byte counts as written only in a cycle where both valid and ready are high. There is no limit on how long ready may stay low. Every other pin is a plain level or a one-cycle pulse. The number of pushed bytes (`PC_BYTES`, 1 to 3) and the vector spacing (`LONG_VEC`) are fixed at build time.

Top module: `irq_entry_seq`

## Requirements
- R1: While `skip_i` is high, no entry is accepted: `busy_o` stays low in the following cycle, whatever the requests are.
- R2: A reset request wins over any pending hardware source. It uses vector number 0, pulses `rst_ack_o` in the load cycle and leaves `pend_clr_o` all zero.
- R3: Without a reset request, the lowest-numbered set bit of `pend_i` wins. Its vector number is that bit index plus 1.
- R4: `pc_new_o` equals the vector number times 2 when `LONG_VEC` is 1, and the vector number times 1 when it is 0.
- R5: Exactly `PC_BYTES` bytes are written. The first goes to the captured stack pointer and each later byte to the address one lower. The data order is PC bits 7:0, then bits 15:8, then bits 23:16.
- R6: While `wr_valid_o` is high and `wr_ready_i` is low, `wr_addr_o` and `wr_data_o` stay unchanged and the sequence does not advance.
- R7: The load cycle lasts exactly one cycle and raises `pc_load_o`, `sp_load_o`, `gie_clr_o` and `vec_taken_o` together. `vec_num_o` carries the vector number and `sp_new_o` equals the captured stack pointer minus `PC_BYTES`.
- R8: In the load cycle of a hardware entry, `pend_clr_o` has exactly one bit set, the serviced source. At all other times it is zero.
- R9: `busy_o` is high from the cycle after acceptance through the load cycle. No new request is accepted while busy. The requests, the PC and the SP are sampled only at acceptance.
- R10: With `gie_i` low, neither a reset request nor a pending source is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rst_req_i | input | 1 | Reset-entry request |
| pend_i | input | NUM_SRC | Pending hardware sources, bit 0 highest priority |
| gie_i | input | 1 | Global interrupt enable |
| skip_i | input | 1 | Next instruction is being skipped |
| pc_i | input | 8*PC_BYTES | Current PC word address (return address) |
| sp_i | input | SP_W | Current stack pointer |
| busy_o | output | 1 | Entry in progress |
| wr_valid_o | output | 1 | Stack byte write valid |
| wr_ready_i | input | 1 | Memory accepts the byte |
| wr_addr_o | output | SP_W | Stack byte address |
| wr_data_o | output | 8 | Stack byte data |
| pc_load_o | output | 1 | Load `pc_new_o` into the PC |
| pc_new_o | output | 8*PC_BYTES | Vector address |
| sp_load_o | output | 1 | Load `sp_new_o` into the SP |
| sp_new_o | output | SP_W | Stack pointer after the pushes |
| gie_clr_o | output | 1 | Clear the global enable flag |
| pend_clr_o | output | NUM_SRC | One-hot mask of the serviced source |
| rst_ack_o | output | 1 | Reset request serviced |
| vec_taken_o | output | 1 | One-cycle pulse at the PC load |
| vec_num_o | output | $clog2(NUM_SRC+1) | Vector number taken |

## Verification
The hardest case to reach is a request that changes while an entry is stalled. Here the pending vector, the PC and the memory ready all move while a push is held off by back-pressure. A result that is still correct then shows that only the values sampled at acceptance matter. The bench drives a pseudo-random ready pattern and changes `pend_i` and `pc_i` in the middle of a push. It also holds `skip_i` or a low `gie_i` across several cycles while requests stay asserted. A cycle-exact behavioural model checks every output on every clock.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PUSH = 2'd1,
    ST_LOAD = 2'd2
  } seq_state_e;

  function automatic int cnt_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int N     = 32,
  parameter int IDX_W = 6
) (
  input  logic [N-1:0]     req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [N-1:0]     onehot_o
);

  logic [N:0] seen;

  assign seen[0] = 1'b0;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_chain
      assign seen[g+1]   = seen[g] | req_i[g];
      assign onehot_o[g] = req_i[g] & ~seen[g];
    end
  endgenerate

  assign any_o = seen[N];

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (onehot_o[i]) idx_o = idx_o | IDX_W'(i);
    end
  end

endmodule

// File: rtl/irq_vec_calc.sv
module irq_vec_calc #(
  parameter int VEC_W    = 6,
  parameter int PC_W     = 24,
  parameter bit LONG_VEC = 1'b1
) (
  input  logic [VEC_W-1:0] vec_i,
  output logic [PC_W-1:0]  pc_o
);

  generate
    if (LONG_VEC) begin : g_two_word
      assign pc_o = PC_W'({vec_i, 1'b0});
    end else begin : g_one_word
      assign pc_o = PC_W'(vec_i);
    end
  endgenerate

endmodule

// File: rtl/irq_push_unit.sv
module irq_push_unit #(
  parameter int PC_BYTES = 3,
  parameter int SP_W     = 16,
  localparam int PC_W    = 8 * PC_BYTES,
  localparam int CNT_W   = irq_seq_pkg::cnt_width(PC_BYTES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [PC_W-1:0] pc_i,
  input  logic [SP_W-1:0] sp_i,
  input  logic            ready_i,
  output logic            valid_o,
  output logic [SP_W-1:0] addr_o,
  output logic [7:0]      data_o,
  output logic [SP_W-1:0] sp_base_o,
  output logic            done_o
);

  logic             active_q;
  logic [CNT_W-1:0] cnt_q;
  logic [PC_W-1:0]  pc_q;
  logic [SP_W-1:0]  sp_q;
  logic [7:0]       bytes [PC_BYTES];
  logic             last;
  logic             fire;

  genvar g;
  generate
    for (g = 0; g < PC_BYTES; g++) begin : g_bytes
      assign bytes[g] = pc_q[8*g +: 8];
    end
  endgenerate

  assign last = (cnt_q == CNT_W'(PC_BYTES - 1));
  assign fire = active_q & ready_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      pc_q     <= '0;
      sp_q     <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
      pc_q     <= pc_i;
      sp_q     <= sp_i;
    end else if (fire) begin
      if (last) active_q <= 1'b0;
      else      cnt_q    <= cnt_q + 1'b1;
    end
  end

  assign valid_o   = active_q;
  assign addr_o    = sp_q - SP_W'(cnt_q);
  assign data_o    = bytes[cnt_q];
  assign sp_base_o = sp_q;
  assign done_o    = fire & last;

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_seq_pkg::*;
#(
  parameter int NUM_SRC  = 32,
  parameter int PC_BYTES = 3,
  parameter int SP_W     = 16,
  parameter bit LONG_VEC = 1'b1,
  localparam int PC_W    = 8 * PC_BYTES,
  localparam int VEC_W   = $clog2(NUM_SRC + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rst_req_i,
  input  logic [NUM_SRC-1:0] pend_i,
  input  logic               gie_i,
  input  logic               skip_i,
  input  logic [PC_W-1:0]    pc_i,
  input  logic [SP_W-1:0]    sp_i,
  output logic               busy_o,
  output logic               wr_valid_o,
  input  logic               wr_ready_i,
  output logic [SP_W-1:0]    wr_addr_o,
  output logic [7:0]         wr_data_o,
  output logic               pc_load_o,
  output logic [PC_W-1:0]    pc_new_o,
  output logic               sp_load_o,
  output logic [SP_W-1:0]    sp_new_o,
  output logic               gie_clr_o,
  output logic [NUM_SRC-1:0] pend_clr_o,
  output logic               rst_ack_o,
  output logic               vec_taken_o,
  output logic [VEC_W-1:0]   vec_num_o
);

  seq_state_e         st_q, st_d;
  logic               enc_any;
  logic [VEC_W-1:0]   enc_idx;
  logic [NUM_SRC-1:0] enc_onehot;
  logic               accept;
  logic               push_done;
  logic [SP_W-1:0]    sp_base;
  logic [VEC_W-1:0]   cap_vec;
  logic [NUM_SRC-1:0] cap_clr;
  logic               cap_rst;
  logic [PC_W-1:0]    vec_pc;
  logic               in_load;

  irq_prio_enc #(
    .N     (NUM_SRC),
    .IDX_W (VEC_W)
  ) u_enc (
    .req_i    (pend_i),
    .any_o    (enc_any),
    .idx_o    (enc_idx),
    .onehot_o (enc_onehot)
  );

  assign accept = (st_q == ST_IDLE) && gie_i && !skip_i && (rst_req_i || enc_any);

  irq_push_unit #(
    .PC_BYTES (PC_BYTES),
    .SP_W     (SP_W)
  ) u_push (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (accept),
    .pc_i      (pc_i),
    .sp_i      (sp_i),
    .ready_i   (wr_ready_i),
    .valid_o   (wr_valid_o),
    .addr_o    (wr_addr_o),
    .data_o    (wr_data_o),
    .sp_base_o (sp_base),
    .done_o    (push_done)
  );

  irq_vec_calc #(
    .VEC_W    (VEC_W),
    .PC_W     (PC_W),
    .LONG_VEC (LONG_VEC)
  ) u_vec (
    .vec_i (cap_vec),
    .pc_o  (vec_pc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_vec <= '0;
      cap_clr <= '0;
      cap_rst <= 1'b0;
    end else if (accept) begin
      cap_rst <= rst_req_i;
      cap_vec <= rst_req_i ? '0 : (enc_idx + VEC_W'(1));
      cap_clr <= rst_req_i ? '0 : enc_onehot;
    end
  end

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (accept)    st_d = ST_PUSH;
      ST_PUSH: if (push_done) st_d = ST_LOAD;
      ST_LOAD:                st_d = ST_IDLE;
      default:                st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign in_load     = (st_q == ST_LOAD);
  assign busy_o      = (st_q != ST_IDLE);
  assign pc_load_o   = in_load;
  assign sp_load_o   = in_load;
  assign gie_clr_o   = in_load;
  assign vec_taken_o = in_load;
  assign rst_ack_o   = in_load & cap_rst;
  assign pc_new_o    = in_load ? vec_pc : '0;
  assign vec_num_o   = in_load ? cap_vec : '0;
  assign sp_new_o    = in_load ? (sp_base - SP_W'(PC_BYTES)) : '0;
  assign pend_clr_o  = in_load ? cap_clr : '0;

endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk #(
  parameter int NUM_SRC = 32,
  parameter int PC_W    = 24,
  parameter int SP_W    = 16,
  parameter int VEC_W   = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               gie_i,
  input logic               skip_i,
  input logic               busy_o,
  input logic               wr_valid_o,
  input logic               wr_ready_i,
  input logic [SP_W-1:0]    wr_addr_o,
  input logic [7:0]         wr_data_o,
  input logic               pc_load_o,
  input logic               sp_load_o,
  input logic               gie_clr_o,
  input logic [NUM_SRC-1:0] pend_clr_o,
  input logic               rst_ack_o,
  input logic               vec_taken_o,
  input logic [VEC_W-1:0]   vec_num_o
);

  p_skip_blocks_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && skip_i) |=> !busy_o);

  p_gie_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !gie_i) |=> !busy_o);

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_o && !wr_ready_i) |=>
      (wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o)));

  p_addr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_o && wr_ready_i) |=>
      (!wr_valid_o || wr_addr_o == SP_W'($past(wr_addr_o) - 1'b1)));

  p_no_write_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !wr_valid_o);

  p_load_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load_o |=> !pc_load_o);

  p_load_bundle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load_o |-> (gie_clr_o && vec_taken_o && sp_load_o && busy_o && !wr_valid_o));

  p_clr_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pend_clr_o));

  p_clr_only_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !pc_load_o |-> (pend_clr_o == '0));

  p_rst_vec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rst_ack_o |-> (vec_num_o == '0 && pend_clr_o == '0 && pc_load_o));

endmodule

bind irq_entry_seq irq_entry_seq_chk #(
  .NUM_SRC (NUM_SRC),
  .PC_W    (PC_W),
  .SP_W    (SP_W),
  .VEC_W   (VEC_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .gie_i       (gie_i),
  .skip_i      (skip_i),
  .busy_o      (busy_o),
  .wr_valid_o  (wr_valid_o),
  .wr_ready_i  (wr_ready_i),
  .wr_addr_o   (wr_addr_o),
  .wr_data_o   (wr_data_o),
  .pc_load_o   (pc_load_o),
  .sp_load_o   (sp_load_o),
  .gie_clr_o   (gie_clr_o),
  .pend_clr_o  (pend_clr_o),
  .rst_ack_o   (rst_ack_o),
  .vec_taken_o (vec_taken_o),
  .vec_num_o   (vec_num_o)
);

// File: tb/irq_entry_seq_tb.sv
module irq_entry_seq_tb;

  localparam int NS    = 32;
  localparam int PB    = 3;
  localparam int SPW   = 16;
  localparam int PCW   = 8 * PB;
  localparam int VW    = $clog2(NS + 1);
  localparam int VSIZE = 2;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           rst_req = 1'b0;
  logic [NS-1:0]  pend = '0;
  logic           gie = 1'b0;
  logic           skip = 1'b0;
  logic [PCW-1:0] pc = '0;
  logic [SPW-1:0] sp = '0;
  logic           wready = 1'b1;
  logic           busy, wvalid, pc_load, sp_load, gie_clr, rst_ack, vtaken;
  logic [SPW-1:0] waddr, sp_new;
  logic [7:0]     wdata;
  logic [PCW-1:0] pc_new;
  logic [NS-1:0]  pend_clr;
  logic [VW-1:0]  vnum;

  always #5 clk = ~clk;

  irq_entry_seq #(.NUM_SRC(NS), .PC_BYTES(PB), .SP_W(SPW), .LONG_VEC(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .rst_req_i(rst_req), .pend_i(pend), .gie_i(gie),
    .skip_i(skip), .pc_i(pc), .sp_i(sp), .busy_o(busy), .wr_valid_o(wvalid),
    .wr_ready_i(wready), .wr_addr_o(waddr), .wr_data_o(wdata), .pc_load_o(pc_load),
    .pc_new_o(pc_new), .sp_load_o(sp_load), .sp_new_o(sp_new), .gie_clr_o(gie_clr),
    .pend_clr_o(pend_clr), .rst_ack_o(rst_ack), .vec_taken_o(vtaken), .vec_num_o(vnum)
  );

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Behavioural reference model
  int             m_mode = 0;
  logic [SPW-1:0] q_addr[$];
  logic [7:0]     q_data[$];
  int             m_vec = 0;
  bit             m_rst = 1'b0;
  logic [SPW-1:0] m_sp = '0;
  int             last_vec = -1;
  longint         last_pc = -1;
  longint         last_clr = -1;
  longint         last_sp = -1;
  int             n_bytes = 0;
  logic [7:0]     last_bytes[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0;
      q_addr.delete();
      q_data.delete();
    end else begin
      case (m_mode)
        0: if (gie && !skip && (rst_req || pend != '0)) begin
             m_rst = rst_req;
             m_vec = 0;
             if (!rst_req) begin
               for (int i = NS - 1; i >= 0; i--) if (pend[i]) m_vec = i + 1;
             end
             m_sp = sp;
             for (int k = 0; k < PB; k++) begin
               q_addr.push_back(sp - SPW'(k));
               q_data.push_back(pc[8*k +: 8]);
             end
             m_mode = 1;
           end
        1: if (wready) begin
             void'(q_addr.pop_front());
             void'(q_data.pop_front());
             if (q_addr.size() == 0) m_mode = 2;
           end
        default: m_mode = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R9", "busy", busy, m_mode != 0);
      chk("R5", "wr_valid", wvalid, m_mode == 1);
      chk("R7", "pc_load", pc_load, m_mode == 2);
      if (m_mode == 1 && wvalid) begin
        chk("R5", "wr_addr", waddr, q_addr[0]);
        chk("R5", "wr_data", wdata, q_data[0]);
        if (wready) last_bytes.push_back(wdata);
      end
      if (m_mode == 2) begin
        chk("R4", "pc_new", pc_new, longint'(m_vec) * VSIZE);
        chk("R7", "vec_num", vnum, m_vec);
        chk("R7", "sp_new", sp_new, SPW'(m_sp - SPW'(PB)));
        chk("R7", "gie_clr", gie_clr, 1);
        chk("R2", "rst_ack", rst_ack, m_rst);
        chk("R8", "pend_clr", pend_clr, m_rst ? 0 : (longint'(1) << (m_vec - 1)));
        last_vec = vnum;
        last_pc  = pc_new;
        last_clr = pend_clr;
        last_sp  = sp_new;
      end else begin
        chk("R8", "pend_clr idle", pend_clr, 0);
      end
    end
  end

  // Memory back-pressure
  bit       bp_en = 1'b0;
  logic [7:0] lfsr = 8'hA5;
  always @(posedge clk) begin
    #1;
    lfsr   <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    wready <= bp_en ? lfsr[0] : 1'b1;
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wait_taken();
    do @(negedge clk); while (!vtaken);
    @(posedge clk);
    #1;
    rst_req = 1'b0;
    pend    = '0;
    step(2);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9", "reset busy", busy, 0);
    chk("R5", "reset wr_valid", wvalid, 0);
    chk("R7", "reset pc_load", pc_load, 0);
    step(1);

    // R3 single source, three-byte push order
    gie = 1'b1; sp = 16'h08FF; pc = 24'h123456;
    last_bytes.delete();
    pend = 32'h0000_0020;
    wait_taken();
    chk("R3", "vec bit5", last_vec, 6);
    chk("R4", "pc bit5", last_pc, 12);
    chk("R5", "byte count", last_bytes.size(), PB);
    if (last_bytes.size() == PB) begin
      chk("R5", "byte0", last_bytes[0], 8'h56);
      chk("R5", "byte1", last_bytes[1], 8'h34);
      chk("R5", "byte2", last_bytes[2], 8'h12);
    end
    chk("R7", "sp_new", last_sp, 16'h08FC);

    // R3 R8 several pending: lowest wins, only it cleared
    pend = 32'h8000_0208; sp = 16'h0400;
    wait_taken();
    chk("R3", "vec multi", last_vec, 4);
    chk("R8", "clr multi", last_clr, 32'h8);

    // R2 reset beats pending
    rst_req = 1'b1; pend = 32'h1;
    wait_taken();
    chk("R2", "vec reset", last_vec, 0);
    chk("R2", "pc reset", last_pc, 0);

    // R1 skip blocks entry
    skip = 1'b1; pend = 32'h4;
    step(5);
    @(negedge clk);
    chk("R1", "busy during skip", busy, 0);
    chk("R1", "no write during skip", wvalid, 0);
    @(posedge clk); #1;
    skip = 1'b0;
    wait_taken();
    chk("R1", "vec after skip", last_vec, 3);

    // R10 gie low blocks reset and interrupts
    gie = 1'b0; rst_req = 1'b1; pend = 32'hFFFF_0000;
    step(5);
    @(negedge clk);
    chk("R10", "busy gie low", busy, 0);
    chk("R10", "no load gie low", pc_load, 0);
    @(posedge clk); #1;
    gie = 1'b1;
    wait_taken();
    chk("R10", "vec after gie", last_vec, 0);

    // R6 back-pressure, R9 inputs changed mid-entry
    bp_en = 1'b1; pend = 32'h80; pc = 24'hABCDEF; sp = 16'h0123;
    last_bytes.delete();
    do @(negedge clk); while (!busy);
    @(posedge clk); #1;
    pend = 32'h1; pc = 24'h000000; sp = 16'hFFFF; rst_req = 1'b1;
    wait_taken();
    chk("R9", "vec captured", last_vec, 8);
    chk("R6", "bytes under bp", last_bytes.size(), PB);
    if (last_bytes.size() == PB) chk("R6", "byte0 bp", last_bytes[0], 8'hEF);
    chk("R9", "sp captured", last_sp, 16'h0120);
    bp_en = 1'b0;

    // R3 R4 edges: highest and lowest sources
    pend = 32'h8000_0000; pc = 24'h000102;
    wait_taken();
    chk("R3", "vec bit31", last_vec, 32);
    chk("R4", "pc bit31", last_pc, 64);
    pend = 32'hFFFF_FFFF;
    wait_taken();
    chk("R3", "vec bit0", last_vec, 1);
    chk("R8", "clr bit0", last_clr, 1);

    step(3);
    done = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

endmodule